// File: doc/BRIEF.md
# Permutation Benchmark Run Sequencer

This block runs a fixed benchmark loop around an external 25-lane permutation engine and builds a 64-bit checksum from the results. Software loads five values: an element count, a frequency divisor, the number of test runs, the number of rounds and a checksum seed. A one-cycle start pulse then hands control to the sequencer.

The sequencer walks a run index upward from zero. For each run it compares the element count with the run index taken modulo the frequency divisor. A selected run seeds a 25-lane state from the run index and sends it through the engine the requested number of times, feeding each result back in as the next input. It then adds the lanes together and XORs that sum into the checksum. Runs that are not selected cost one cycle and leave the checksum alone.

The engine is reached over a start/done handshake that carries the whole 1600-bit state each way. When the loop ends the sequencer raises `done` for one cycle and holds the final checksum on its output.

Top module: `perm_bench_seq`

## Requirements
- R1: Run indices go from 0 to run-count minus 1. A run executes only when the element count is strictly greater than (run index mod frequency). Runs that are not selected issue no permutation.
- R2: A frequency value of 0 behaves exactly like a frequency of 1, so that every index mod frequency is 0.
- R3: At the start of a selected run, lane i (i = 0..24, held in bits [64*i+63 : 64*i] of the state vector) equals i + run index as a 64-bit value. This is the state carried by the run's first `perm_start`.
- R4: Within a selected run the engine is started exactly round-count times. Each start after the first carries the state that the previous `perm_done` returned. With a round count of 0 the seeded state is folded directly.
- R5: The result of a run is the 64-bit wrap-around sum of its 25 lanes after the last permutation.
- R6: When a start is accepted, the checksum loads the seed value. Each executed run XORs its result into the checksum, and a skipped run leaves it unchanged. While idle the checksum output holds its value.
- R7: `perm_start` is a single-cycle pulse. No new pulse is issued before `perm_done` answers the previous one. `perm_state_out` is taken only in a cycle in which `perm_done` is high.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` pulses. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R9: A start pulse while `busy` is high is ignored, and so are changes on the configuration inputs while busy. The checksum then equals the value computed from the configuration present at the accepted start.
- R10: A run count of 0 completes with `done` and a checksum equal to the seed, and no permutation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only while idle |
| cfg_elems | input | 32 | Element count compared against run index mod frequency |
| cfg_freq | input | 32 | Frequency divisor (0 treated as 1) |
| cfg_runs | input | 32 | Number of test runs |
| cfg_rounds | input | 32 | Permutations per selected run |
| cfg_seed | input | 64 | Initial checksum value |
| perm_start | output | 1 | One-cycle request to the permutation engine |
| perm_state_in | output | 1600 | State sent to the engine, lane i at bits 64*i+63:64*i |
| perm_done | input | 1 | Engine result valid |
| perm_state_out | input | 1600 | State returned by the engine |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| checksum | output | 64 | Running and final checksum |

## Verification
The hardest situation to reach from the ports is a start pulse, with new configuration values, arriving while a run waits on the engine. The stimulus places that pulse in the middle of a long engine latency and leaves the inputs disturbed until `done`. It then checks that the final checksum and the sequence of engine requests still follow the first configuration. The stand-in engine returns a bench-side mixing function with an adjustable latency and puts junk on its output between answers, so a state taken outside a `perm_done` cycle corrupts the comparison. Every `perm_start` is matched against a queue of expected states built beforehand, which exposes wrong selection, seeding or chaining at the exact request where it occurs.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int CNT_W = 32;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t elems;
        cnt_t freq;
        cnt_t runs;
        cnt_t rounds;
    } seq_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_ISSUE,
        S_WAIT,
        S_FOLD,
        S_FINISH
    } seq_state_e;

    function automatic cnt_t norm_freq(input cnt_t f);
        return (f == '0) ? cnt_t'(1) : f;
    endfunction

endpackage

// File: rtl/run_stepper.sv
module run_stepper
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    input  logic active,
    input  cnt_t elems,
    input  cnt_t freq,
    input  cnt_t runs,
    output cnt_t run_idx,
    output logic last,
    output logic selected
);
    cnt_t idx_q;
    cnt_t phase_q;
    cnt_t phase_nxt;

    assign phase_nxt = phase_q + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q   <= '0;
            phase_q <= '0;
        end else if (advance) begin
            idx_q   <= idx_q + cnt_t'(1);
            phase_q <= (phase_nxt == freq) ? '0 : phase_nxt;
        end
    end

    assign run_idx  = idx_q;
    assign last     = (idx_q == runs);
    assign selected = (elems > phase_q);

    // phase counter stands for run index mod freq and must stay below it
    assert_phase_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> (phase_q < freq));

    // run index never passes the run count
    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (rst)
        active |-> (idx_q <= runs));

endmodule

// File: rtl/lane_seed.sv
module lane_seed
    import seq_pkg::*;
#(
    parameter int LANES  = 25,
    parameter int LANE_W = 64
) (
    input  cnt_t                      run_idx,
    output logic [LANES*LANE_W-1:0]   seed
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign seed[i*LANE_W +: LANE_W] = LANE_W'(i) + LANE_W'(run_idx);
    end
endmodule

// File: rtl/lane_fold.sv
module lane_fold #(
    parameter int LANES  = 25,
    parameter int LANE_W = 64
) (
    input  logic [LANES*LANE_W-1:0] state,
    output logic [LANE_W-1:0]       sum
);
    logic [LANE_W-1:0] partial [LANES+1];

    assign partial[0] = '0;
    for (genvar i = 0; i < LANES; i++) begin : g_add
        assign partial[i+1] = partial[i] + state[i*LANE_W +: LANE_W];
    end
    assign sum = partial[LANES];
endmodule

// File: rtl/perm_bench_seq.sv
module perm_bench_seq
    import seq_pkg::*;
#(
    parameter int LANES  = 25,
    parameter int LANE_W = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [CNT_W-1:0]           cfg_elems,
    input  logic [CNT_W-1:0]           cfg_freq,
    input  logic [CNT_W-1:0]           cfg_runs,
    input  logic [CNT_W-1:0]           cfg_rounds,
    input  logic [LANE_W-1:0]          cfg_seed,
    output logic                       perm_start,
    output logic [LANES*LANE_W-1:0]    perm_state_in,
    input  logic                       perm_done,
    input  logic [LANES*LANE_W-1:0]    perm_state_out,
    output logic                       busy,
    output logic                       done,
    output logic [LANE_W-1:0]          checksum
);
    localparam int STATE_W = LANES * LANE_W;

    seq_state_e               fsm_q;
    seq_cfg_t                 cfg_q;
    logic [STATE_W-1:0]       st_q;
    logic [LANE_W-1:0]        chk_q;
    cnt_t                     round_q;
    cnt_t                     round_nxt;

    cnt_t                     run_idx;
    logic                     run_last;
    logic                     run_sel;
    logic                     accept;
    logic                     step;
    logic [STATE_W-1:0]       seed_vec;
    logic [LANE_W-1:0]        fold_sum;

    assign accept    = (fsm_q == S_IDLE) && start;
    assign step      = ((fsm_q == S_EVAL) && !run_last && !run_sel) || (fsm_q == S_FOLD);
    assign round_nxt = round_q + cnt_t'(1);

    run_stepper u_stepper (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .advance  (step),
        .active   (busy),
        .elems    (cfg_q.elems),
        .freq     (cfg_q.freq),
        .runs     (cfg_q.runs),
        .run_idx  (run_idx),
        .last     (run_last),
        .selected (run_sel)
    );

    lane_seed #(.LANES(LANES), .LANE_W(LANE_W)) u_seed (
        .run_idx (run_idx),
        .seed    (seed_vec)
    );

    lane_fold #(.LANES(LANES), .LANE_W(LANE_W)) u_fold (
        .state (st_q),
        .sum   (fold_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= S_IDLE;
            cfg_q   <= '0;
            st_q    <= '0;
            chk_q   <= '0;
            round_q <= '0;
        end else begin
            case (fsm_q)
                S_IDLE: begin
                    if (start) begin
                        cfg_q.elems  <= cfg_elems;
                        cfg_q.freq   <= norm_freq(cfg_freq);
                        cfg_q.runs   <= cfg_runs;
                        cfg_q.rounds <= cfg_rounds;
                        chk_q        <= cfg_seed;
                        fsm_q        <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    if (run_last) begin
                        fsm_q <= S_FINISH;
                    end else if (run_sel) begin
                        st_q    <= seed_vec;
                        round_q <= '0;
                        fsm_q   <= (cfg_q.rounds == '0) ? S_FOLD : S_ISSUE;
                    end
                end
                S_ISSUE: fsm_q <= S_WAIT;
                S_WAIT: begin
                    if (perm_done) begin
                        st_q    <= perm_state_out;
                        round_q <= round_nxt;
                        fsm_q   <= (round_nxt == cfg_q.rounds) ? S_FOLD : S_ISSUE;
                    end
                end
                S_FOLD: begin
                    chk_q <= chk_q ^ fold_sum;
                    fsm_q <= S_EVAL;
                end
                S_FINISH: fsm_q <= S_IDLE;
                default:  fsm_q <= S_IDLE;
            endcase
        end
    end

    assign perm_start    = (fsm_q == S_ISSUE);
    assign perm_state_in = st_q;
    assign busy          = (fsm_q != S_IDLE);
    assign done          = (fsm_q == S_FINISH);
    assign checksum      = chk_q;

    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        perm_start |=> !perm_start);

    // state may only change on the cycle the engine answers
    assert_hold_until_done_R7: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == S_WAIT && !perm_done) |=> $stable(st_q));

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));

    assert_idle_checksum_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(checksum));

    assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(cfg_q));

endmodule

// File: tb/perm_bench_seq_bench.sv
module perm_bench_seq_bench;
    localparam int LANES = 25;
    localparam int LW    = 64;
    localparam int SW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [31:0]   cfg_elems, cfg_freq, cfg_runs, cfg_rounds;
    logic [63:0]   cfg_seed;
    logic          perm_start;
    logic [SW-1:0] perm_state_in;
    logic          perm_done;
    logic [SW-1:0] perm_state_out;
    logic          busy, done;
    logic [63:0]   checksum;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    logic timeout = 1'b0;

    logic [SW-1:0] exp_q[$];
    int            lat_cfg = 1;
    logic          pending = 1'b0;
    int            cnt = 0;
    logic [SW-1:0] captured = '0;

    always #2 clk = ~clk;

    perm_bench_seq u_perm_bench_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_elems(cfg_elems), .cfg_freq(cfg_freq), .cfg_runs(cfg_runs),
        .cfg_rounds(cfg_rounds), .cfg_seed(cfg_seed),
        .perm_start(perm_start), .perm_state_in(perm_state_in),
        .perm_done(perm_done), .perm_state_out(perm_state_out),
        .busy(busy), .done(done), .checksum(checksum)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) timeout <= 1'b1;
    end

    function automatic logic [SW-1:0] mix(input logic [SW-1:0] s);
        logic [SW-1:0] o;
        for (int i = 0; i < LANES; i++) begin
            logic [63:0] a;
            logic [63:0] r;
            a = s[((i*7+3)%LANES)*LW +: LW];
            r = (a << (i+1)) | (a >> (63-i));
            o[i*LW +: LW] = r ^ (s[i*LW +: LW] + 64'h9E3779B97F4A7C15 * 64'(i+1));
        end
        return o;
    endfunction

    function automatic logic [63:0] lane_sum(input logic [SW-1:0] s);
        logic [63:0] t = '0;
        for (int i = 0; i < LANES; i++) t = t + s[i*LW +: LW];
        return t;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stand-in engine and per-clock handshake model (R3, R4, R7)
    always @(negedge clk) begin
        if (rst) begin
            perm_done <= 1'b0;
            pending   = 1'b0;
        end else begin
            if (perm_done) perm_done <= 1'b0;
            perm_state_out <= ~captured ^ {LANES{64'(cycles)}};
            if (pending) begin
                if (cnt <= 1) begin
                    perm_done      <= 1'b1;
                    perm_state_out <= mix(captured);
                    pending = 1'b0;
                end else cnt--;
            end
            if (perm_start) begin
                check64("R7 start while outstanding", 64'(pending), 64'd0);
                if (exp_q.size() == 0) begin
                    check64("R1 unexpected perm_start", 64'd1, 64'd0);
                end else begin
                    logic [SW-1:0] e;
                    e = exp_q.pop_front();
                    check64("R3/R4 state at perm_start", lane_sum(perm_state_in) ^ perm_state_in[63:0],
                            lane_sum(e) ^ e[63:0]);
                    n_checks++;
                    if (perm_state_in !== e) begin
                        n_err++;
                        $display("FAIL R4 full state mismatch actual=%h expected=%h",
                                 perm_state_in[63:0], e[63:0]);
                    end
                end
                captured = perm_state_in;
                pending  = 1'b1;
                cnt      = lat_cfg;
            end
        end
    end

    task automatic run_case(input string tag, input logic [31:0] el, input logic [31:0] fr,
                            input logic [31:0] rn, input logic [31:0] rd,
                            input logic [63:0] sd, input int lat, input bit poke);
        logic [63:0] exp_chk;
        logic [31:0] fe;
        exp_chk = sd;
        fe = (fr == 0) ? 32'd1 : fr;
        exp_q.delete();
        for (int idx = 0; idx < int'(rn); idx++) begin
            if (el > 32'(idx) % fe) begin
                logic [SW-1:0] s;
                for (int i = 0; i < LANES; i++) s[i*LW +: LW] = 64'(i) + 64'(idx);
                for (int r = 0; r < int'(rd); r++) begin
                    exp_q.push_back(s);
                    s = mix(s);
                end
                exp_chk = exp_chk ^ lane_sum(s);
            end
        end
        lat_cfg = lat;
        cfg_elems = el; cfg_freq = fr; cfg_runs = rn; cfg_rounds = rd; cfg_seed = sd;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check64({tag, " R8 busy after start"}, 64'(busy), 64'd1);
        if (poke) begin
            repeat (5) @(negedge clk);
            cfg_elems = 32'd0; cfg_runs = 32'd1; cfg_seed = 64'h1234; cfg_rounds = 32'd9;
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            check64({tag, " R9 busy held"}, 64'(busy), 64'd1);
        end
        while (!done && !timeout) @(negedge clk);
        check64({tag, " R6 checksum"}, checksum, exp_chk);
        check64({tag, " R4 all requests issued"}, 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check64({tag, " R8 done one cycle"}, 64'(done), 64'd0);
        check64({tag, " R8 busy cleared"}, 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        check64({tag, " R6 idle hold"}, checksum, exp_chk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        cfg_elems = '0; cfg_freq = '0; cfg_runs = '0; cfg_rounds = '0; cfg_seed = '0;
        perm_done = 1'b0; perm_state_out = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check64("R8 reset busy", 64'(busy), 64'd0);
        check64("R8 reset done", 64'(done), 64'd0);
        check64("R7 reset perm_start", 64'(perm_start), 64'd0);
        check64("R6 reset checksum", checksum, 64'd0);

        run_case("R1 mixed selection", 32'd3, 32'd5, 32'd12, 32'd2, 64'hA5A5_0000_FFFF_1234, 1, 0);
        run_case("R2 freq zero", 32'd1, 32'd0, 32'd4, 32'd1, 64'h0F0F_0F0F_0F0F_0F0F, 3, 0);
        run_case("R1 none selected", 32'd0, 32'd4, 32'd6, 32'd2, 64'hDEAD_BEEF_0000_0001, 1, 0);
        run_case("R4 zero rounds", 32'd2, 32'd3, 32'd7, 32'd0, 64'h1111_2222_3333_4444, 1, 0);
        run_case("R10 zero runs", 32'd5, 32'd2, 32'd0, 32'd3, 64'h7777_0000_7777_0000, 1, 0);
        run_case("R5 all selected", 32'd100, 32'd4, 32'd6, 32'd3, 64'h0, 2, 0);
        run_case("R9 start while busy", 32'd2, 32'd3, 32'd5, 32'd2, 64'hCAFE_F00D_0000_0042, 6, 1);
        run_case("R3 high run index", 32'd1, 32'd7, 32'd15, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);

        if (timeout) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule